// File: doc/BRIEF.md
# Multipath Fork and Resolve Tracker

This block keeps the multipath bookkeeping for the hardware contexts of one core. A speculative thread starts on a free context. When a context reaches a branch that has been flagged low confidence, the block picks a free context on the same core and forks the other direction into it. From then on, every context records three things: whether it is in multipath mode, how many forked branches it still has outstanding, and which direction it took at each of those levels. Forks may nest up to a configurable depth.

Branches resolve oldest first. On each resolve, every context of the thread whose direction bit at the oldest level does not match the outcome is freed and flagged. Each surviving context shifts its direction history down one level and lowers its count by one. A context leaves multipath mode when its count reaches zero.

While any context of a thread is in multipath mode, commit, restart and kill requests for that thread's contexts are latched and not issued. Spawning from a context in multipath mode is held off in the same way. Latched requests are released once the hold ends. A context that turns out to be on the wrong path takes its latched requests with it, so a violation seen only on that path never causes a squash.

Top module: `mpt_tracker`

## Requirements
- R1: After reset no context is live, every mode, count and direction output is zero, and no hold, issue or drop output is high.
- R2: A start request on a context that is not live makes it live on the next cycle in normal mode with count 0, direction 0 and thread tag equal to its own index. A start request on a context that is already live is ignored.
- R3: A branch report with `br_lowconf_i` high, on a live context whose count is below DEPTH, when a free context exists, raises `fork_ok_o` in the same cycle. `fork_ctx_o` is then the lowest-index context that is not live and is not the target of a start in that cycle. On the next cycle both contexts have count c+1, where c is the source's old count, and the same thread tag. The source's direction bit c is 0. The new context holds the source's direction bits with bit c set to 1.
- R4: No fork happens when the branch is not low confidence, the reporting context is not live, its count already equals DEPTH, or no free context exists. In that case `fork_ok_o` is low and the state is unchanged.
- R5: A resolve names any context of a thread that is in multipath mode, plus an outcome bit. The outcome is 0 when the path that stayed in the original context was correct and 1 when the forked path was. Every multipath context of that thread whose direction bit 0 differs from the outcome is freed on the next cycle, with `drop_o` high for one cycle. Every matching context has its count decreased by one and its direction shifted right by one. `mp_o` is high exactly while the count is nonzero.
- R6: `hold_o[i]` is high exactly when context i is live and some live context with the same thread tag has a nonzero count. `spawn_hold_o[i]` is high exactly when context i is live and its own count is nonzero.
- R7: Request codes are 0 for commit, 1 for restart and 2 for kill; code 3 is ignored. A request on a live context whose hold is high is latched. It is issued as a one-cycle pulse on the cycle after the first cycle in which that hold is low.
- R8: A request on a live context whose hold is low is issued on the next cycle. A request on a context that is not live is ignored.
- R9: When several request kinds are pending together, only one is issued: kill before restart, restart before commit. Issuing clears every pending kind of that context.
- R10: Requests pending on a context that is freed by a resolve are discarded and never issued.
- R11: A retire request frees a live context whose count is zero. It is ignored on a context in multipath mode, on a context that is not live, and on a context that is the source of a fork in the same cycle.
- R12: A fork and a resolve in the same cycle both take effect when they concern different threads. A fork whose source belongs to the thread being resolved is refused. Contexts freed by a resolve are not offered to a fork in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_vld_i | input | 1 | Start a thread on a context |
| start_ctx_i | input | IW | Context to start |
| done_vld_i | input | 1 | Retire a context |
| done_ctx_i | input | IW | Context to retire |
| br_vld_i | input | 1 | Branch report valid |
| br_lowconf_i | input | 1 | Branch flagged low confidence |
| br_ctx_i | input | IW | Context reporting the branch |
| fork_ok_o | output | 1 | Fork accepted this cycle |
| fork_ctx_o | output | IW | Context receiving the forked path |
| rs_vld_i | input | 1 | Oldest forked branch resolved |
| rs_ctx_i | input | IW | Any multipath context of the resolving thread |
| rs_dir_i | input | 1 | Correct direction at the oldest level |
| req_vld_i | input | 1 | Commit, restart or kill request |
| req_ctx_i | input | IW | Context the request is for |
| req_kind_i | input | 2 | 0 commit, 1 restart, 2 kill |
| live_o | output | NCTX | Context occupied |
| mp_o | output | NCTX | Context in multipath mode |
| paths_o | output | NCTX*PW | Outstanding fork count per context |
| dir_o | output | NCTX*DEPTH | Direction history per context |
| hold_o | output | NCTX | Commit, restart and kill held |
| spawn_hold_o | output | NCTX | Thread spawn held |
| drop_o | output | NCTX | Context discarded as wrong path |
| iss_commit_o | output | NCTX | Commit released |
| iss_restart_o | output | NCTX | Restart released |
| iss_kill_o | output | NCTX | Kill released |

## Verification
Two pairs of events can land in the same cycle. A resolve can coincide with a fork, and a resolve can coincide with a request on a context of the thread being resolved. The bench provokes both by driving all request channels at once with independent random choices for several thousand cycles, after a directed opening that fills the fork depth. A cycle-level model built from the requirements predicts which fork is refused, which contexts survive, which latched requests vanish with a discarded path, and in which cycle each issue pulse appears. Every output is compared against the model each cycle.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  typedef enum logic [1:0] {
    REQ_COMMIT  = 2'd0,
    REQ_RESTART = 2'd1,
    REQ_KILL    = 2'd2,
    REQ_NONE    = 2'd3
  } req_kind_e;

  // pending vector: bit0 commit, bit1 restart, bit2 kill
  function automatic logic [2:0] req_bit(input logic [1:0] kind);
    case (kind)
      REQ_COMMIT:  req_bit = 3'b001;
      REQ_RESTART: req_bit = 3'b010;
      REQ_KILL:    req_bit = 3'b100;
      default:     req_bit = 3'b000;
    endcase
  endfunction

  // kill beats restart beats commit
  function automatic logic [2:0] pick_issue(input logic [2:0] pend);
    if (pend[2])      pick_issue = 3'b100;
    else if (pend[1]) pick_issue = 3'b010;
    else if (pend[0]) pick_issue = 3'b001;
    else              pick_issue = 3'b000;
  endfunction
endpackage

// File: rtl/mpt_alloc.sv
module mpt_alloc #(
  parameter int NCTX  = 6,
  parameter int DEPTH = 3,
  parameter int PW    = 3,
  parameter int IW    = 3
) (
  input  logic [NCTX-1:0]         live,
  input  logic [NCTX-1:0][PW-1:0] paths,
  input  logic [NCTX-1:0][IW-1:0] gid,
  input  logic                    br_vld,
  input  logic                    br_lowconf,
  input  logic [IW-1:0]           br_ctx,
  input  logic                    start_fire,
  input  logic [IW-1:0]           start_ctx,
  input  logic                    res_fire,
  input  logic [IW-1:0]           res_grp,
  output logic                    fork_fire,
  output logic [IW-1:0]           fork_dst
);
  logic          found;
  logic          src_ok;
  logic          same_thread;
  logic [IW-1:0] sidx;

  assign sidx = (int'(br_ctx) < NCTX) ? br_ctx : '0;

  always_comb begin
    found    = 1'b0;
    fork_dst = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (!found && !live[i] && !(start_fire && start_ctx == IW'(i))) begin
        found    = 1'b1;
        fork_dst = IW'(i);
      end
    end
  end

  assign src_ok = br_vld && br_lowconf && (int'(br_ctx) < NCTX) && live[sidx] &&
                  (paths[sidx] < PW'(DEPTH));
  assign same_thread = res_fire && (gid[sidx] == res_grp);
  assign fork_fire = src_ok && found && !same_thread;
endmodule

// File: rtl/mpt_state.sv
module mpt_state #(
  parameter int NCTX  = 6,
  parameter int DEPTH = 3,
  parameter int PW    = 3,
  parameter int IW    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_fire,
  input  logic [IW-1:0]              start_ctx,
  input  logic                       done_fire,
  input  logic [IW-1:0]              done_ctx,
  input  logic                       fork_fire,
  input  logic [IW-1:0]              fork_src,
  input  logic [IW-1:0]              fork_dst,
  input  logic                       res_fire,
  input  logic [IW-1:0]              res_grp,
  input  logic                       res_dir,
  output logic [NCTX-1:0]            live_q,
  output logic [NCTX-1:0][PW-1:0]    paths_q,
  output logic [NCTX-1:0][DEPTH-1:0] dir_q,
  output logic [NCTX-1:0][IW-1:0]    gid_q,
  output logic [NCTX-1:0]            disc,
  output logic [NCTX-1:0]            drop_q
);
  logic [NCTX-1:0]            member;
  logic [NCTX-1:0]            n_live;
  logic [NCTX-1:0][PW-1:0]    n_paths;
  logic [NCTX-1:0][DEPTH-1:0] n_dir;
  logic [NCTX-1:0][IW-1:0]    n_gid;

  function automatic logic [DEPTH-1:0] level_mask(input logic [PW-1:0] lvl);
    level_mask = DEPTH'(1) << lvl;
  endfunction

  for (genvar g = 0; g < NCTX; g++) begin : g_member
    assign member[g] = res_fire && live_q[g] && (paths_q[g] != '0) && (gid_q[g] == res_grp);
    assign disc[g]   = member[g] && (dir_q[g][0] != res_dir);
  end

  always_comb begin
    for (int i = 0; i < NCTX; i++) begin
      n_live[i]  = live_q[i];
      n_paths[i] = paths_q[i];
      n_dir[i]   = dir_q[i];
      n_gid[i]   = gid_q[i];
      if (member[i]) begin
        if (disc[i]) begin
          n_live[i]  = 1'b0;
          n_paths[i] = '0;
          n_dir[i]   = '0;
          n_gid[i]   = '0;
        end else begin
          n_paths[i] = paths_q[i] - PW'(1);
          n_dir[i]   = dir_q[i] >> 1;
        end
      end else if (fork_fire && fork_src == IW'(i)) begin
        n_paths[i] = paths_q[i] + PW'(1);
      end else if (fork_fire && fork_dst == IW'(i)) begin
        n_live[i]  = 1'b1;
        n_paths[i] = paths_q[fork_src] + PW'(1);
        n_dir[i]   = dir_q[fork_src] | level_mask(paths_q[fork_src]);
        n_gid[i]   = gid_q[fork_src];
      end else if (start_fire && start_ctx == IW'(i)) begin
        n_live[i]  = 1'b1;
        n_paths[i] = '0;
        n_dir[i]   = '0;
        n_gid[i]   = IW'(i);
      end else if (done_fire && done_ctx == IW'(i)) begin
        n_live[i]  = 1'b0;
        n_paths[i] = '0;
        n_dir[i]   = '0;
        n_gid[i]   = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q  <= '0;
      paths_q <= '0;
      dir_q   <= '0;
      gid_q   <= '0;
      drop_q  <= '0;
    end else begin
      live_q  <= n_live;
      paths_q <= n_paths;
      dir_q   <= n_dir;
      gid_q   <= n_gid;
      drop_q  <= disc;
    end
  end
endmodule

// File: rtl/mpt_hold.sv
module mpt_hold
  import mpt_pkg::*;
#(
  parameter int NCTX = 6,
  parameter int PW   = 3,
  parameter int IW   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCTX-1:0]         live,
  input  logic [NCTX-1:0][PW-1:0] paths,
  input  logic [NCTX-1:0][IW-1:0] gid,
  input  logic [NCTX-1:0]         disc,
  input  logic                    req_vld,
  input  logic [IW-1:0]           req_ctx,
  input  logic [1:0]              req_kind,
  output logic [NCTX-1:0]         hold,
  output logic [NCTX-1:0]         spawn_hold,
  output logic [NCTX-1:0]         iss_commit,
  output logic [NCTX-1:0]         iss_restart,
  output logic [NCTX-1:0]         iss_kill
);
  logic [NCTX-1:0]       grp_mp;
  logic [NCTX-1:0][2:0]  pend_q;
  logic [NCTX-1:0][2:0]  pend_n;
  logic [NCTX-1:0][2:0]  iss_q;

  always_comb begin
    grp_mp = '0;
    for (int g = 0; g < NCTX; g++)
      for (int j = 0; j < NCTX; j++)
        if (live[j] && (paths[j] != '0) && (gid[j] == IW'(g))) grp_mp[g] = 1'b1;
  end

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    assign hold[i]        = live[i] && (int'(gid[i]) < NCTX) && grp_mp[gid[i]];
    assign spawn_hold[i]  = live[i] && (paths[i] != '0);
    assign pend_n[i]      = pend_q[i] |
                            ((req_vld && req_ctx == IW'(i)) ? req_bit(req_kind) : 3'b000);
    assign iss_commit[i]  = iss_q[i][0];
    assign iss_restart[i] = iss_q[i][1];
    assign iss_kill[i]    = iss_q[i][2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      iss_q  <= '0;
    end else begin
      for (int i = 0; i < NCTX; i++) begin
        if (disc[i] || !live[i]) begin
          pend_q[i] <= 3'b000;
          iss_q[i]  <= 3'b000;
        end else if (!hold[i] && (pend_n[i] != 3'b000)) begin
          pend_q[i] <= 3'b000;
          iss_q[i]  <= pick_issue(pend_n[i]);
        end else begin
          pend_q[i] <= pend_n[i];
          iss_q[i]  <= 3'b000;
        end
      end
    end
  end
endmodule

// File: rtl/mpt_tracker.sv
module mpt_tracker #(
  parameter int NCTX  = 6,
  parameter int DEPTH = 3,
  localparam int PW   = $clog2(DEPTH + 2),
  localparam int IW   = $clog2(NCTX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_vld_i,
  input  logic [IW-1:0]         start_ctx_i,
  input  logic                  done_vld_i,
  input  logic [IW-1:0]         done_ctx_i,
  input  logic                  br_vld_i,
  input  logic                  br_lowconf_i,
  input  logic [IW-1:0]         br_ctx_i,
  output logic                  fork_ok_o,
  output logic [IW-1:0]         fork_ctx_o,
  input  logic                  rs_vld_i,
  input  logic [IW-1:0]         rs_ctx_i,
  input  logic                  rs_dir_i,
  input  logic                  req_vld_i,
  input  logic [IW-1:0]         req_ctx_i,
  input  logic [1:0]            req_kind_i,
  output logic [NCTX-1:0]       live_o,
  output logic [NCTX-1:0]       mp_o,
  output logic [NCTX*PW-1:0]    paths_o,
  output logic [NCTX*DEPTH-1:0] dir_o,
  output logic [NCTX-1:0]       hold_o,
  output logic [NCTX-1:0]       spawn_hold_o,
  output logic [NCTX-1:0]       drop_o,
  output logic [NCTX-1:0]       iss_commit_o,
  output logic [NCTX-1:0]       iss_restart_o,
  output logic [NCTX-1:0]       iss_kill_o
);
  logic [NCTX-1:0]            live_q;
  logic [NCTX-1:0][PW-1:0]    paths_q;
  logic [NCTX-1:0][DEPTH-1:0] dir_q;
  logic [NCTX-1:0][IW-1:0]    gid_q;
  logic [NCTX-1:0]            disc;

  logic          start_fire, done_fire, res_fire, fork_fire;
  logic [IW-1:0] start_idx, done_idx, rs_idx, fork_dst, res_grp;

  function automatic logic [IW-1:0] safe_idx(input logic [IW-1:0] c);
    safe_idx = (int'(c) < NCTX) ? c : '0;
  endfunction

  assign start_idx  = safe_idx(start_ctx_i);
  assign done_idx   = safe_idx(done_ctx_i);
  assign rs_idx     = safe_idx(rs_ctx_i);

  assign start_fire = start_vld_i && (int'(start_ctx_i) < NCTX) && !live_q[start_idx];
  assign res_fire   = rs_vld_i && (int'(rs_ctx_i) < NCTX) && live_q[rs_idx] &&
                      (paths_q[rs_idx] != '0);
  assign res_grp    = gid_q[rs_idx];
  assign done_fire  = done_vld_i && (int'(done_ctx_i) < NCTX) && live_q[done_idx] &&
                      (paths_q[done_idx] == '0) && !(fork_fire && br_ctx_i == done_ctx_i);

  mpt_alloc #(.NCTX(NCTX), .DEPTH(DEPTH), .PW(PW), .IW(IW)) u_alloc (
    .live(live_q), .paths(paths_q), .gid(gid_q),
    .br_vld(br_vld_i), .br_lowconf(br_lowconf_i), .br_ctx(br_ctx_i),
    .start_fire(start_fire), .start_ctx(start_ctx_i),
    .res_fire(res_fire), .res_grp(res_grp),
    .fork_fire(fork_fire), .fork_dst(fork_dst)
  );

  mpt_state #(.NCTX(NCTX), .DEPTH(DEPTH), .PW(PW), .IW(IW)) u_state (
    .clk(clk), .rst_n(rst_n),
    .start_fire(start_fire), .start_ctx(start_ctx_i),
    .done_fire(done_fire), .done_ctx(done_ctx_i),
    .fork_fire(fork_fire), .fork_src(br_ctx_i), .fork_dst(fork_dst),
    .res_fire(res_fire), .res_grp(res_grp), .res_dir(rs_dir_i),
    .live_q(live_q), .paths_q(paths_q), .dir_q(dir_q), .gid_q(gid_q),
    .disc(disc), .drop_q(drop_o)
  );

  mpt_hold #(.NCTX(NCTX), .PW(PW), .IW(IW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .live(live_q), .paths(paths_q), .gid(gid_q), .disc(disc),
    .req_vld(req_vld_i), .req_ctx(req_ctx_i), .req_kind(req_kind_i),
    .hold(hold_o), .spawn_hold(spawn_hold_o),
    .iss_commit(iss_commit_o), .iss_restart(iss_restart_o), .iss_kill(iss_kill_o)
  );

  assign fork_ok_o  = fork_fire;
  assign fork_ctx_o = fork_dst;
  assign live_o     = live_q;

  for (genvar i = 0; i < NCTX; i++) begin : g_out
    assign mp_o[i]                   = paths_q[i] != '0;
    assign paths_o[i*PW +: PW]       = paths_q[i];
    assign dir_o[i*DEPTH +: DEPTH]   = dir_q[i];
  end
endmodule

// File: rtl/mpt_tracker_chk.sv
module mpt_tracker_chk #(
  parameter int NCTX  = 6,
  parameter int DEPTH = 3,
  parameter int PW    = 3,
  parameter int IW    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  br_vld_i,
  input logic                  br_lowconf_i,
  input logic                  fork_ok_o,
  input logic [IW-1:0]         fork_ctx_o,
  input logic [NCTX-1:0]       live_o,
  input logic [NCTX-1:0]       mp_o,
  input logic [NCTX*PW-1:0]    paths_o,
  input logic [NCTX*DEPTH-1:0] dir_o,
  input logic [NCTX-1:0]       hold_o,
  input logic [NCTX-1:0]       spawn_hold_o,
  input logic [NCTX-1:0]       drop_o,
  input logic [NCTX-1:0]       iss_commit_o,
  input logic [NCTX-1:0]       iss_restart_o,
  input logic [NCTX-1:0]       iss_kill_o
);
  p_fork_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fork_ok_o |-> !live_o[fork_ctx_o]);

  p_fork_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fork_ok_o |=> (live_o[$past(fork_ctx_o)] && mp_o[$past(fork_ctx_o)]));

  p_fork_lowconf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fork_ok_o |-> (br_vld_i && br_lowconf_i));

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    p_dir_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir_o[i*DEPTH +: DEPTH] >> paths_o[i*PW +: PW]) == '0));

    p_spawn_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_hold_o[i] |-> hold_o[i]);

    p_one_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iss_kill_o[i], iss_restart_o[i], iss_commit_o[i]}));

    p_issue_unheld_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_kill_o[i] || iss_restart_o[i] || iss_commit_o[i]) |->
        ($past(live_o[i]) && !$past(hold_o[i])));

    p_drop_wrong_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o[i] |-> (!live_o[i] && $past(mp_o[i])));
  end
endmodule

bind mpt_tracker mpt_tracker_chk #(.NCTX(NCTX), .DEPTH(DEPTH), .PW(PW), .IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .br_vld_i(br_vld_i), .br_lowconf_i(br_lowconf_i),
  .fork_ok_o(fork_ok_o), .fork_ctx_o(fork_ctx_o), .live_o(live_o), .mp_o(mp_o),
  .paths_o(paths_o), .dir_o(dir_o), .hold_o(hold_o), .spawn_hold_o(spawn_hold_o),
  .drop_o(drop_o), .iss_commit_o(iss_commit_o), .iss_restart_o(iss_restart_o),
  .iss_kill_o(iss_kill_o)
);

// File: tb/test_mpt_tracker.sv
module test_mpt_tracker;
  localparam int N  = 6;
  localparam int D  = 3;
  localparam int PW = 3;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic st_v, dn_v, br_v, br_lc, rs_v, rs_d, rq_v;
  logic [IW-1:0] st_c, dn_c, br_c, rs_c, rq_c;
  logic [1:0] rq_k;
  logic fork_ok;
  logic [IW-1:0] fork_ctx;
  logic [N-1:0] live, mp, hold, shold, drop, ic, ir, ik;
  logic [N*PW-1:0] paths;
  logic [N*D-1:0] dir;

  mpt_tracker i_mpt_tracker (
    .clk(clk), .rst_n(rst_n),
    .start_vld_i(st_v), .start_ctx_i(st_c), .done_vld_i(dn_v), .done_ctx_i(dn_c),
    .br_vld_i(br_v), .br_lowconf_i(br_lc), .br_ctx_i(br_c),
    .fork_ok_o(fork_ok), .fork_ctx_o(fork_ctx),
    .rs_vld_i(rs_v), .rs_ctx_i(rs_c), .rs_dir_i(rs_d),
    .req_vld_i(rq_v), .req_ctx_i(rq_c), .req_kind_i(rq_k),
    .live_o(live), .mp_o(mp), .paths_o(paths), .dir_o(dir),
    .hold_o(hold), .spawn_hold_o(shold), .drop_o(drop),
    .iss_commit_o(ic), .iss_restart_o(ir), .iss_kill_o(ik)
  );

  int n_chk = 0;
  int n_err = 0;
  int m_live[N], m_paths[N], m_dir[N], m_gid[N], m_pend[N];
  int e_iss[N], e_drop[N];
  string t_live[N], t_st[N], t_iss[N];

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int m_hold(int i);
    if (m_live[i] == 0) return 0;
    for (int k = 0; k < N; k++)
      if (m_live[k] != 0 && m_paths[k] != 0 && m_gid[k] == m_gid[i]) return 1;
    return 0;
  endfunction

  function automatic int pick(int p);
    if ((p & 4) != 0) return 4;
    if ((p & 2) != 0) return 2;
    if ((p & 1) != 0) return 1;
    return 0;
  endfunction

  task automatic idle();
    st_v = 0; dn_v = 0; br_v = 0; br_lc = 0; rs_v = 0; rs_d = 0; rq_v = 0;
    st_c = 0; dn_c = 0; br_c = 0; rs_c = 0; rq_c = 0; rq_k = 0;
  endtask

  task automatic compare_all();
    for (int i = 0; i < N; i++) begin
      chk(t_live[i], $sformatf("live[%0d]", i), int'(live[i]), m_live[i]);
      chk(t_st[i], $sformatf("paths[%0d]", i), int'(paths[i*PW +: PW]), m_paths[i]);
      chk(t_st[i], $sformatf("dir[%0d]", i), int'(dir[i*D +: D]), m_dir[i]);
      chk("R5", $sformatf("mp[%0d]", i), int'(mp[i]), (m_paths[i] != 0) ? 1 : 0);
      chk("R6", $sformatf("hold[%0d]", i), int'(hold[i]), m_hold(i));
      chk("R6", $sformatf("spawn_hold[%0d]", i), int'(shold[i]),
          (m_live[i] != 0 && m_paths[i] != 0) ? 1 : 0);
      chk("R5", $sformatf("drop[%0d]", i), int'(drop[i]), e_drop[i]);
      chk(t_iss[i], $sformatf("issue[%0d]", i), int'({ik[i], ir[i], ic[i]}), e_iss[i]);
    end
  endtask

  task automatic step();
    int o_live[N], o_paths[N], o_dir[N], o_gid[N], o_pend[N], hv[N];
    bit s_fire, r_fire, f_fire, f_cand, f_same, d_fire, found;
    int r_g, free_c, bc;
    #1;
    o_live = m_live; o_paths = m_paths; o_dir = m_dir; o_gid = m_gid; o_pend = m_pend;
    for (int i = 0; i < N; i++) hv[i] = m_hold(i);
    s_fire = st_v && int'(st_c) < N && o_live[st_c] == 0;
    r_fire = rs_v && int'(rs_c) < N && o_live[rs_c] != 0 && o_paths[rs_c] != 0;
    r_g = (int'(rs_c) < N) ? o_gid[rs_c] : -1;
    found = 0; free_c = 0;
    for (int j = 0; j < N; j++)
      if (!found && o_live[j] == 0 && !(s_fire && int'(st_c) == j)) begin
        found = 1; free_c = j;
      end
    bc = int'(br_c);
    f_cand = br_v && br_lc && bc < N && o_live[bc] != 0 && o_paths[bc] < D && found;
    f_same = r_fire && bc < N && o_gid[bc] == r_g;
    f_fire = f_cand && !f_same;
    chk(f_fire ? "R3" : (f_cand ? "R12" : "R4"), "fork_ok", int'(fork_ok), int'(f_fire));
    if (f_fire) chk("R3", "fork_ctx", int'(fork_ctx), free_c);
    d_fire = dn_v && int'(dn_c) < N && o_live[dn_c] != 0 && o_paths[dn_c] == 0 &&
             !(f_fire && br_c == dn_c);
    for (int i = 0; i < N; i++) begin
      int pn, inc;
      bit mem;
      t_live[i] = "R2"; t_st[i] = "R2"; e_drop[i] = 0;
      mem = r_fire && o_live[i] != 0 && o_paths[i] != 0 && o_gid[i] == r_g;
      if (mem) begin
        t_live[i] = "R5"; t_st[i] = "R5";
        if ((o_dir[i] & 1) != int'(rs_d)) begin
          m_live[i] = 0; m_paths[i] = 0; m_dir[i] = 0; m_gid[i] = 0; e_drop[i] = 1;
        end else begin
          m_paths[i] = o_paths[i] - 1; m_dir[i] = o_dir[i] >> 1;
        end
      end else if (f_fire && i == bc) begin
        t_st[i] = "R3"; m_paths[i] = o_paths[i] + 1;
      end else if (f_fire && i == free_c) begin
        t_live[i] = "R3"; t_st[i] = "R3";
        m_live[i] = 1; m_paths[i] = o_paths[bc] + 1;
        m_dir[i] = o_dir[bc] | (1 << o_paths[bc]); m_gid[i] = o_gid[bc];
      end else if (s_fire && i == int'(st_c)) begin
        m_live[i] = 1; m_paths[i] = 0; m_dir[i] = 0; m_gid[i] = i;
      end else if (d_fire && i == int'(dn_c)) begin
        t_live[i] = "R11"; m_live[i] = 0; m_paths[i] = 0; m_dir[i] = 0; m_gid[i] = 0;
      end else if (dn_v && i == int'(dn_c)) begin
        t_live[i] = "R11";
      end
      inc = (rq_v && int'(rq_c) == i && rq_k != 2'd3) ? (1 << rq_k) : 0;
      pn = o_pend[i] | inc;
      if (e_drop[i] != 0 || o_live[i] == 0) begin
        t_iss[i] = (e_drop[i] != 0 && pn != 0) ? "R10" : "R8";
        m_pend[i] = 0; e_iss[i] = 0;
      end else if (hv[i] == 0 && pn != 0) begin
        e_iss[i] = pick(pn); m_pend[i] = 0;
        t_iss[i] = ($countones(pn) > 1) ? "R9" : ((o_pend[i] != 0) ? "R7" : "R8");
      end else begin
        t_iss[i] = (hv[i] != 0) ? "R7" : "R8";
        m_pend[i] = pn; e_iss[i] = 0;
      end
    end
    @(posedge clk);
    #1;
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      m_live[i] = 0; m_paths[i] = 0; m_dir[i] = 0; m_gid[i] = 0; m_pend[i] = 0;
      e_iss[i] = 0; e_drop[i] = 0;
    end
    // R1: reset state
    chk("R1", "live", int'(live), 0);
    chk("R1", "mp", int'(mp), 0);
    chk("R1", "paths", int'(paths), 0);
    chk("R1", "dir", int'(dir), 0);
    chk("R1", "hold", int'(hold | shold | drop), 0);
    chk("R1", "issue", int'(ic | ir | ik), 0);
    rst_n = 1;

    // directed: start, duplicate start, nest forks to full depth, refused fork
    idle(); st_v = 1; st_c = 0; step();
    idle(); st_v = 1; st_c = 0; step();
    for (int k = 0; k < 4; k++) begin
      idle(); br_v = 1; br_lc = 1; br_c = 0; step();
    end
    idle(); rq_v = 1; rq_c = 0; rq_k = 2'd0; step();
    idle(); rq_v = 1; rq_c = 0; rq_k = 2'd2; step();
    idle(); rq_v = 1; rq_c = 1; rq_k = 2'd1; step();
    idle(); dn_v = 1; dn_c = 0; step();
    idle(); rs_v = 1; rs_c = 0; rs_d = 0; step();
    idle(); rs_v = 1; rs_c = 0; rs_d = 1; step();
    idle(); rs_v = 1; rs_c = 2; rs_d = 0; step();
    idle(); step();
    idle(); br_v = 1; br_lc = 0; br_c = 2; step();

    // broad sweep with all channels active at once
    for (int k = 0; k < 5000; k++) begin
      idle();
      st_v  = ($urandom_range(0, 99) < 35);
      st_c  = IW'($urandom_range(0, N - 1));
      dn_v  = ($urandom_range(0, 99) < 12);
      dn_c  = IW'($urandom_range(0, N - 1));
      br_v  = ($urandom_range(0, 99) < 50);
      br_lc = ($urandom_range(0, 99) < 75);
      br_c  = IW'($urandom_range(0, N - 1));
      rs_v  = ($urandom_range(0, 99) < 30);
      rs_c  = IW'($urandom_range(0, N - 1));
      rs_d  = $urandom_range(0, 1) != 0;
      rq_v  = ($urandom_range(0, 99) < 45);
      rq_c  = IW'($urandom_range(0, N - 1));
      rq_k  = 2'($urandom_range(0, 3));
      step();
    end

    idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule